// File: doc/BRIEF.md
# Blanked Multi-Cycle Fault Qualifier

This block turns a raw protection comparator flag (over-voltage or over-temperature on a shared sense input) into a confirmed fault. It is designed for a fixed-frequency power switching controller. One switching cycle runs from one rising edge of the gate drive signal to the next. After each gate turn-off, the comparator is ignored for a blanking interval, so that the ringing from the transformer's leakage inductance cannot trip it. Once blanking has ended, a comparator high only counts as an event for that cycle if it stays high without a gap for a minimum number of clock samples. Each cycle can contribute at most one event.

At every rising edge of the gate signal, the block closes the cycle that just ended. A cycle that held an event extends a run of consecutive faulty cycles. A cycle without an event resets the run to zero. When the run reaches the configured length, the confirmed-fault output is set. It then stays set until a clear pulse or a reset, so that the surrounding controller can stop switching and go through its auto-recovery restart. The current run length is brought out for debug.

Top module: `fault_qualifier`

## Requirements
- R1: The comparator is ignored at the clock edge where a falling edge of `drv` is first seen, and for the BLANK_CYC clock edges after it. A high level that begins during blanking counts only from the first sample after blanking.
- R2: A cycle holds an event only if `cmp_high` is sampled high on MIN_HIGH_CYC consecutive edges after blanking. A shorter high, or one broken by a low sample, gives no event.
- R3: `fault_confirmed` rises at the `drv` rising edge that closes the RUN_LEN-th consecutive cycle holding an event.
- R4: At most one event is counted per cycle, however long the comparator stays high, so `event_count` rises by at most one per cycle.
- R5: Once set, `fault_confirmed` stays high through later cycles, including cycles with no event, until `clr_fault` or `rst`.
- R6: A cycle that closes without an event sets `event_count` to 0.
- R7: The qualification window closes at the rising edge of `drv`. Samples taken at or after that edge do not count toward the cycle that is closing.
- R8: `rst` (synchronous, active high) forces `fault_confirmed` and `event_count` to 0. A `clr_fault` pulse does the same and takes priority over a cycle closing in the same clock.
- R9: `event_count` gives the current run of consecutive event cycles, updated one clock after the closing `drv` rise and saturating at RUN_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv | input | 1 | Gate drive signal; rising edge marks a cycle boundary |
| cmp_high | input | 1 | Protection comparator output |
| clr_fault | input | 1 | Pulse to clear the confirmed fault and the run |
| fault_confirmed | output | 1 | Sticky confirmed-fault flag |
| event_count | output | $clog2(RUN_LEN+1) | Consecutive event cycles (debug) |

## Verification
The bench builds the block with BLANK_CYC=4, MIN_HIGH_CYC=3 and RUN_LEN=4, using a switching cycle of 4 clocks high and 16 clocks low. This leaves an 11-sample window after blanking. In that window the bench can place pulses exactly at the minimum width, one sample short, straddling the end of blanking, and cut off by the next rise. With these values the full four-cycle run to a confirmed fault fits in a few hundred clocks. The clear-versus-rise collision and the sticky flag through an empty cycle can also be reached directly.

// File: rtl/fq_pkg.sv
package fq_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_BLANK = 2'd1,
    WIN_WATCH = 2'd2
  } win_state_t;
endpackage

// File: rtl/fq_edge.sv
module fq_edge (
  input  logic clk,
  input  logic rst,
  input  logic drv_i,
  output logic rise_o,
  output logic fall_o
);
  logic drv_q;

  always_ff @(posedge clk) begin
    if (rst) drv_q <= 1'b0;
    else     drv_q <= drv_i;
  end

  assign rise_o = drv_i & ~drv_q;
  assign fall_o = ~drv_i & drv_q;
endmodule

// File: rtl/fq_window.sv
module fq_window
  import fq_pkg::*;
#(
  parameter int BLANK_CYC    = 100,
  parameter int MIN_HIGH_CYC = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic fall_i,
  input  logic cmp_i,
  output logic seen_o
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int HW = $clog2(MIN_HIGH_CYC + 1);

  win_state_t    st;
  logic [BW-1:0] blank_cnt;
  logic [HW-1:0] hi_cnt;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= WIN_IDLE;
      blank_cnt <= '0;
      hi_cnt    <= '0;
      seen_q    <= 1'b0;
    end else if (rise_i) begin
      st     <= WIN_IDLE;
      hi_cnt <= '0;
      seen_q <= 1'b0;
    end else if (fall_i) begin
      st        <= WIN_BLANK;
      blank_cnt <= '0;
      hi_cnt    <= '0;
    end else begin
      case (st)
        WIN_BLANK: begin
          if (blank_cnt == BW'(BLANK_CYC - 1)) begin
            st     <= WIN_WATCH;
            hi_cnt <= '0;
          end else begin
            blank_cnt <= blank_cnt + 1'b1;
          end
        end
        WIN_WATCH: begin
          if (cmp_i) begin
            if (hi_cnt == HW'(MIN_HIGH_CYC - 1)) seen_q <= 1'b1;
            else                                 hi_cnt <= hi_cnt + 1'b1;
          end else begin
            hi_cnt <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign seen_o = seen_q;

  AST_ONE_EVENT_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !rise_i) |=> seen_q); // R4
  AST_EVENT_NEEDS_CMP: assert property (@(posedge clk) disable iff (rst)
    $rose(seen_q) |-> $past(cmp_i)); // R2
endmodule

// File: rtl/fq_run.sv
module fq_run #(
  parameter int RUN_LEN = 4,
  localparam int RW = $clog2(RUN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          rise_i,
  input  logic          seen_i,
  output logic [RW-1:0] run_o,
  output logic          fault_o
);
  logic [RW-1:0] run_q;
  logic [RW-1:0] run_nxt;
  logic          fault_q;

  always_comb begin
    if (!seen_i)                   run_nxt = '0;
    else if (run_q == RW'(RUN_LEN)) run_nxt = run_q;
    else                           run_nxt = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      run_q   <= '0;
      fault_q <= 1'b0;
    end else if (rise_i) begin
      run_q <= run_nxt;
      if (run_nxt == RW'(RUN_LEN)) fault_q <= 1'b1;
    end
  end

  assign run_o   = run_q;
  assign fault_o = fault_q;

  AST_RUN_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_q != $past(run_q)) |-> (run_q == '0 || run_q == $past(run_q) + 1'b1)); // R4
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_q <= RW'(RUN_LEN)); // R9
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !clr_i) |=> fault_q); // R5
  AST_FAULT_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_q) |-> (run_q == RW'(RUN_LEN))); // R3
endmodule

// File: rtl/fault_qualifier.sv
module fault_qualifier #(
  parameter int BLANK_CYC    = 100,
  parameter int MIN_HIGH_CYC = 60,
  parameter int RUN_LEN      = 4,
  localparam int RW = $clog2(RUN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drv,
  input  logic          cmp_high,
  input  logic          clr_fault,
  output logic          fault_confirmed,
  output logic [RW-1:0] event_count
);
  logic rise, fall, seen;

  fq_edge u_edge (
    .clk(clk), .rst(rst), .drv_i(drv), .rise_o(rise), .fall_o(fall)
  );

  fq_window #(.BLANK_CYC(BLANK_CYC), .MIN_HIGH_CYC(MIN_HIGH_CYC)) u_window (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall), .cmp_i(cmp_high),
    .seen_o(seen)
  );

  fq_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst(rst), .clr_i(clr_fault), .rise_i(rise), .seen_i(seen),
    .run_o(event_count), .fault_o(fault_confirmed)
  );
endmodule

// File: tb/fault_qualifier_bench.sv
module fault_qualifier_bench;
  localparam int CLK_P = 10;
  localparam int BLANK = 4;
  localparam int MINH  = 3;
  localparam int RUNL  = 4;
  localparam int RW    = $clog2(RUNL + 1);
  localparam int LOWC  = 16;
  localparam int NV    = 13;
  // start offset, length, expected run, expected fault
  localparam int VEC [0:NV-1][0:3] = '{
    '{0, 4, 0, 0},   // R1 entirely blanked
    '{5, 3, 1, 0},   // R2 exact minimum width
    '{5, 2, 0, 0},   // R2 short, R6 clears run
    '{6, 3, 1, 0},
    '{8, 8, 2, 0},   // R4 long high counts once
    '{3, 5, 3, 0},   // R1 straddles blanking end
    '{14, 3, 0, 0},  // R7 cut by rise, R6
    '{5, 3, 1, 0},
    '{7, 6, 2, 0},
    '{9, 3, 3, 0},
    '{5, 9, 4, 1},   // R3 fault on fourth
    '{0, 0, 0, 1},   // R5 sticky, R6 run cleared
    '{5, 3, 1, 1}    // R9 run restarts
  };

  logic clk = 1'b0, rst = 1'b1, drv = 1'b0, cmp_high = 1'b0, clr_fault = 1'b0;
  logic          fault_confirmed;
  logic [RW-1:0] event_count;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  fault_qualifier #(.BLANK_CYC(BLANK), .MIN_HIGH_CYC(MINH), .RUN_LEN(RUNL)) u_fault_qualifier (
    .clk(clk), .rst(rst), .drv(drv), .cmp_high(cmp_high), .clr_fault(clr_fault),
    .fault_confirmed(fault_confirmed), .event_count(event_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // low phase with a comparator pulse, then the closing rise; returns at the negedge after the rise edge
  task automatic sw_cycle(input int st, input int len, input bit clr_at_rise);
    drv = 1'b0;
    for (int i = 0; i < LOWC; i++) begin
      cmp_high = (i >= st) && (i < st + len);
      @(negedge clk);
    end
    cmp_high = 1'b0;
    drv = 1'b1;
    clr_fault = clr_at_rise;
    @(negedge clk);
    clr_fault = 1'b0;
  endtask

  task automatic hold_high();
    for (int i = 0; i < 3; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset fault", fault_confirmed, 0);
    check("R8 reset count", event_count, 0);
    rst = 1'b0;
    drv = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 first rise count", event_count, 0);

    for (int v = 0; v < NV; v++) begin
      sw_cycle(VEC[v][0], VEC[v][1], 1'b0);
      check($sformatf("R9 vec%0d count", v), event_count, VEC[v][2]);
      check($sformatf("R3 R5 vec%0d fault", v), fault_confirmed, VEC[v][3]);
      hold_high();
    end

    // R8 clear pulse during high phase
    clr_fault = 1'b1;
    @(negedge clk);
    clr_fault = 1'b0;
    check("R8 clear fault", fault_confirmed, 0);
    check("R8 clear count", event_count, 0);
    hold_high();

    // R8 clear collides with a rise that closes an event cycle
    sw_cycle(5, 3, 1'b0);
    hold_high();
    sw_cycle(5, 3, 1'b1);
    check("R8 clear beats rise count", event_count, 0);
    check("R8 clear beats rise fault", fault_confirmed, 0);
    hold_high();

    // R2 two short pulses split by a low sample
    sw_cycle(5, 3, 1'b0);
    hold_high();
    drv = 1'b0;
    for (int i = 0; i < LOWC; i++) begin
      cmp_high = (i == 5) || (i == 6) || (i == 8) || (i == 9);
      @(negedge clk);
    end
    cmp_high = 1'b0;
    drv = 1'b1;
    @(negedge clk);
    check("R2 split pulse count", event_count, 0);
    hold_high();

    // R8 reset mid-run
    sw_cycle(5, 3, 1'b0);
    check("R9 before reset count", event_count, 1);
    rst = 1'b1;
    @(negedge clk);
    check("R8 mid-run reset count", event_count, 0);
    rst = 1'b0;
    hold_high();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule